// File: doc/BRIEF.md
# SPI Master Transmit Queue

This block is the transmit half of an SPI master. A one-byte holding buffer sits in front of an 8-bit shift register, so software can queue the next byte while the current one is being shifted out. The block reports a buffer-empty flag, which software polls. In DMA mode it also raises a request line.

The buffer can be filled in two ways, chosen by `dma_en`:

- **Processor mode (`dma_en` = 0).** A write to the data location is accepted only if the preceding status read returned the empty flag set. Any other write is dropped.
- **DMA mode (`dma_en` = 1).** Writes stage the byte without that gate. The `dma_done` pulse then commits the staged byte and clears the flag.

The serial engine uses SPI mode 0. `sck` idles low. `sdo` changes only as `sck` falls, and bytes go out MSB first. The `sck` half period is a fixed parameter. When a byte finishes and a queued byte is waiting, the queued byte starts with no idle gap. When no byte is waiting, the engine returns to idle.

Top module: `spi_txq`

## Requirements
- R1: After reset `tx_empty` is 1, `sck` and `sdo` are 0, and `dma_req` is 0 while `dma_en` is 0.
- R2: With `dma_en` = 0, a data write is discarded unless a status read sampled `tx_empty` = 1 after the last data write. A discarded write leaves `tx_empty` at 1 and produces no `sck` activity.
- R3: With `dma_en` = 0, an accepted write clears `tx_empty` on the next cycle. If the shifter is idle, `tx_empty` is 1 again two cycles after the write.
- R4: Each byte is sent MSB first as 8 `sck` pulses. Each pulse is DIV_HALF cycles high, preceded by DIV_HALF cycles low. `sdo` changes only while `sck` falls or when the shifter is idle.
- R5: A byte accepted while the shifter is busy keeps `tx_empty` at 0 until the current byte ends. It then starts at once, so consecutive `sck` rising edges stay exactly 2·DIV_HALF cycles apart.
- R6: When a byte ends with the buffer empty, `sck` and `sdo` return to 0 and `tx_empty` stays 1.
- R7: `dma_req` equals `dma_en` AND `tx_empty` at all times.
- R8: With `dma_en` = 1, a data write stages the byte without a status read. A `dma_done` pulse while `tx_empty` = 1 then clears `tx_empty` on the next cycle, and the staged byte is transmitted.
- R9: A status read that samples `tx_empty` = 0 does not enable a later data write.
- R10: One qualifying status read enables only one data write. A second write with no new read in between is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stat | input | 1 | Status read strobe; arms the gate if `tx_empty` is 1 |
| wr_data | input | 1 | Data write strobe |
| wdata | input | DW | Byte to queue |
| dma_en | input | 1 | Selects DMA fill mode |
| dma_done | input | 1 | DMA transfer completion pulse |
| sdo | output | 1 | Serial data out, MSB first |
| sck | output | 1 | Serial clock, idle low |
| tx_empty | output | 1 | Holding buffer empty flag |
| dma_req | output | 1 | DMA request for a new byte |

## Verification
The hardest situation to reach is a gapless stream: every byte must be queued during the previous byte, using a fresh status read each time. The bench sweeps all 256 byte values in one stream. It polls the flag, reads the status and writes as soon as the flag rises. It then confirms that every `sck` rising edge in the stream is exactly one period after the previous one, and that every byte arrives in order. The stale-read case needs a read issued while a queued byte holds the flag at 0, followed by a write after the flag rises. The bench builds this by queueing a byte behind an active one.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

   typedef enum logic {
      FILL_CPU = 1'b0,
      FILL_DMA = 1'b1
   } fill_mode_e;

endpackage

// File: rtl/txq_holdbuf.sv
module txq_holdbuf
   import spi_txq_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stat,
   input  logic          wr_data,
   input  logic [DW-1:0] wdata,
   input  logic          dma_en,
   input  logic          dma_done,
   input  logic          take,
   output logic          full,
   output logic [DW-1:0] hold_q
);

   fill_mode_e mode;
   logic       armed;
   logic       cpu_acc;
   logic       dma_stage;
   logic       dma_commit;

   assign mode       = dma_en ? FILL_DMA : FILL_CPU;
   assign cpu_acc    = (mode == FILL_CPU) && wr_data && armed;
   assign dma_stage  = (mode == FILL_DMA) && wr_data && !full;
   assign dma_commit = (mode == FILL_DMA) && dma_done && !full;

   // the gate: a read that saw an empty buffer licenses one write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (wr_data) begin
         armed <= 1'b0;
      end else if (rd_stat) begin
         armed <= !full;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (cpu_acc || dma_stage) begin
         hold_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (cpu_acc || dma_commit) begin
         full <= 1'b1;
      end
   end

endmodule

// File: rtl/txq_shifter.sv
module txq_shifter #(
   parameter int DW       = 8,
   parameter int DIV_HALF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_ok,
   input  logic [DW-1:0] load_data,
   output logic          take,
   output logic          busy,
   output logic          sck,
   output logic          sdo
);

   localparam int BW = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

   logic [DW-1:0] shreg;
   logic [BW-1:0] bitcnt;
   logic          sck_q;
   logic          half_tick;
   logic          byte_done;

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign half_tick = busy;
      end else begin : g_div
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!busy || cnt == CNT_TOP) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign half_tick = busy && (cnt == CNT_TOP);
      end
   endgenerate

   assign byte_done = half_tick && sck_q && (bitcnt == LAST_BIT);
   assign take      = load_ok && (!busy || byte_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
         sck_q  <= 1'b0;
         busy   <= 1'b0;
      end else if (take) begin
         shreg  <= load_data;
         bitcnt <= '0;
         sck_q  <= 1'b0;
         busy   <= 1'b1;
      end else if (byte_done) begin
         bitcnt <= '0;
         sck_q  <= 1'b0;
         busy   <= 1'b0;
      end else if (half_tick) begin
         sck_q <= !sck_q;
         if (sck_q) begin
            shreg  <= shreg << 1;
            bitcnt <= bitcnt + 1'b1;
         end
      end
   end

   assign sck = sck_q;
   assign sdo = busy && shreg[DW-1];

endmodule

// File: rtl/spi_txq.sv
module spi_txq #(
   parameter int DW       = 8,
   parameter int DIV_HALF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stat,
   input  logic          wr_data,
   input  logic [DW-1:0] wdata,
   input  logic          dma_en,
   input  logic          dma_done,
   output logic          sdo,
   output logic          sck,
   output logic          tx_empty,
   output logic          dma_req
);

   initial begin
      assert (DW >= 2) else $error("spi_txq: DW must be at least 2");
      assert (DIV_HALF >= 1) else $error("spi_txq: DIV_HALF must be at least 1");
   end

   logic          buf_full;
   logic [DW-1:0] buf_data;
   logic          take;
   logic          shift_busy;

   txq_holdbuf #(.DW(DW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stat  (rd_stat),
      .wr_data  (wr_data),
      .wdata    (wdata),
      .dma_en   (dma_en),
      .dma_done (dma_done),
      .take     (take),
      .full     (buf_full),
      .hold_q   (buf_data)
   );

   txq_shifter #(.DW(DW), .DIV_HALF(DIV_HALF)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_ok   (buf_full),
      .load_data (buf_data),
      .take      (take),
      .busy      (shift_busy),
      .sck       (sck),
      .sdo       (sdo)
   );

   assign tx_empty = !buf_full;
   assign dma_req  = dma_en && !buf_full;

endmodule

// File: rtl/txq_chk.sv
module txq_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_stat,
   input logic wr_data,
   input logic dma_en,
   input logic dma_done,
   input logic tx_empty,
   input logic dma_req,
   input logic sck,
   input logic sdo,
   input logic shift_busy
);

   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else if (wr_data) begin
         arm_q <= 1'b0;
      end else if (rd_stat) begin
         arm_q <= tx_empty;
      end
   end

   AST_IGNORE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !dma_en && !arm_q && tx_empty) |=> tx_empty); // R2

   AST_CPU_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !dma_en && arm_q) |=> !tx_empty); // R3

   AST_IDLE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !dma_en && arm_q && !shift_busy) |-> ##2 tx_empty); // R3

   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(sdo)); // R4

   AST_QUEUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_empty && shift_busy && !sck) |=> !tx_empty); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_busy |-> (!sck && !sdo)); // R6

   AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !dma_req); // R7

   AST_DMA_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && dma_done && tx_empty) |=> !tx_empty); // R8

endmodule

bind spi_txq txq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_stat    (rd_stat),
   .wr_data    (wr_data),
   .dma_en     (dma_en),
   .dma_done   (dma_done),
   .tx_empty   (tx_empty),
   .dma_req    (dma_req),
   .sck        (sck),
   .sdo        (sdo),
   .shift_busy (shift_busy)
);

// File: tb/sim_spi_txq.sv
`timescale 1ns/1ps
module sim_spi_txq;

   localparam int DW = 8;
   localparam int DH = 2;
   localparam int PERIOD = 2 * DH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_stat = 1'b0;
   logic          wr_data = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          dma_en = 1'b0;
   logic          dma_done = 1'b0;
   logic          sdo, sck, tx_empty, dma_req;

   always #2 clk = ~clk;

   spi_txq #(.DW(DW), .DIV_HALF(DH)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .wr_data(wr_data),
      .wdata(wdata), .dma_en(dma_en), .dma_done(dma_done),
      .sdo(sdo), .sck(sck), .tx_empty(tx_empty), .dma_req(dma_req)
   );

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   bit done_flag = 0;

   logic [7:0] rx_mem [0:511];
   int   rx_n = 0;
   int   rx_bits = 0;
   logic [7:0] rx_sh = '0;
   logic prev_sck = 1'b0;
   int   last_rise = 0;
   bit   had_rise = 0;
   bit   gap_watch = 0;
   int   bad_gap = 0;
   int   dma_mis = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // serial capture and continuous request check
   always @(negedge clk) begin
      if (rst_n) begin
         if (dma_req !== (dma_en && tx_empty)) dma_mis++;
         if (sck && !prev_sck) begin
            if (gap_watch && had_rise && (cyc - last_rise) != PERIOD) bad_gap++;
            last_rise = cyc;
            had_rise = 1;
            rx_sh = {rx_sh[6:0], sdo};
            rx_bits++;
            if (rx_bits == DW) begin
               rx_mem[rx_n] = rx_sh;
               rx_n++;
               rx_bits = 0;
            end
         end
      end
      prev_sck = sck;
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !done_flag) begin
         done_flag = 1;
         nerr++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  CHECKS %0d ERRORS %0d", nchk + 1, nerr);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cpu_read();
      @(negedge clk); rd_stat = 1'b1;
      @(negedge clk); rd_stat = 1'b0;
   endtask

   task automatic cpu_write(input logic [7:0] v);
      @(negedge clk); wr_data = 1'b1; wdata = v;
      @(negedge clk); wr_data = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_empty();
      while (tx_empty !== 1'b1) @(negedge clk);
   endtask

   initial begin
      int base;
      idle(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
      chk(sck === 1'b0 && sdo === 1'b0, "R1 serial idle", {sck, sdo}, 0);
      chk(dma_req === 1'b0, "R1 dma_req", dma_req, 0);

      // R2 write without a prior status read is dropped
      cpu_write(8'hA5);
      chk(tx_empty === 1'b1, "R2 flag after unarmed write", tx_empty, 1);
      idle(40);
      chk(rx_n == 0 && sck === 1'b0, "R2 no serial activity", rx_n, 0);

      // R3 idle handoff timing
      cpu_read();
      cpu_write(8'h3C);
      chk(tx_empty === 1'b0, "R3 flag clears after accepted write", tx_empty, 0);
      @(negedge clk);
      chk(tx_empty === 1'b1, "R3 flag back within two cycles", tx_empty, 1);
      idle(50);
      chk(rx_n == 1 && rx_mem[0] == 8'h3C, "R4 single byte MSB first", rx_mem[0], 8'h3C);
      chk(sck === 1'b0 && sdo === 1'b0 && tx_empty === 1'b1, "R6 idle after byte", {sck, sdo, tx_empty}, 1);

      // R10 one read licenses one write
      cpu_read();
      cpu_write(8'hD1);
      cpu_write(8'hE2);
      idle(80);
      chk(rx_n == 2, "R10 second write dropped count", rx_n, 2);
      chk(rx_mem[1] == 8'hD1, "R10 first write sent", rx_mem[1], 8'hD1);

      // R9 stale read while flag is 0 does not arm
      cpu_read();
      cpu_write(8'h11);
      @(negedge clk);
      cpu_read();
      cpu_write(8'h22);
      chk(tx_empty === 1'b0, "R5 queued byte holds flag low", tx_empty, 0);
      cpu_read();
      chk(tx_empty === 1'b0, "R9 flag still low during stale read", tx_empty, 0);
      wait_empty();
      cpu_write(8'h33);
      chk(tx_empty === 1'b1, "R9 write after stale read dropped", tx_empty, 1);
      idle(120);
      chk(rx_n == 4, "R9 byte count", rx_n, 4);
      chk(rx_mem[2] == 8'h11 && rx_mem[3] == 8'h22, "R5 queued order", {rx_mem[2], rx_mem[3]}, 16'h1122);

      // R4 R5 full sweep of byte values as one gapless stream
      base = rx_n;
      had_rise = 0;
      bad_gap = 0;
      gap_watch = 1;
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         wait_empty();
         cpu_read();
         cpu_write(8'(v));
      end
      wait_empty();
      idle(2 * DW * DH + 20);
      gap_watch = 0;
      chk(rx_n == base + 256, "R4 sweep byte count", rx_n - base, 256);
      for (int v = 0; v < 256; v++) begin
         chk(rx_mem[base + v] == 8'(v), "R4 sweep byte value", rx_mem[base + v], v);
      end
      chk(bad_gap == 0, "R5 gapless sck spacing", bad_gap, 0);

      // R7 R8 DMA mode
      @(negedge clk);
      dma_en = 1'b1;
      @(negedge clk);
      chk(dma_req === 1'b1, "R7 request when empty", dma_req, 1);
      base = rx_n;
      cpu_write(8'h5A);
      chk(tx_empty === 1'b1, "R8 staged write leaves flag set", tx_empty, 1);
      dma_done = 1'b1;
      @(negedge clk);
      dma_done = 1'b0;
      chk(tx_empty === 1'b0 && dma_req === 1'b0, "R8 done clears flag and request", {tx_empty, dma_req}, 0);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         while (dma_req !== 1'b1) @(negedge clk);
         cpu_write(8'(8'h5A ^ (i * 37 + 1)));
         dma_done = 1'b1;
         @(negedge clk);
         dma_done = 1'b0;
      end
      wait_empty();
      idle(2 * DW * DH + 20);
      chk(rx_n == base + 17, "R8 DMA byte count", rx_n - base, 17);
      chk(rx_mem[base] == 8'h5A, "R8 first DMA byte", rx_mem[base], 8'h5A);
      for (int i = 0; i < 16; i++) begin
         chk(rx_mem[base + 1 + i] == 8'(8'h5A ^ (i * 37 + 1)), "R8 DMA byte value",
             rx_mem[base + 1 + i], 8'(8'h5A ^ (i * 37 + 1)));
      end
      dma_en = 1'b0;
      @(negedge clk);
      chk(dma_req === 1'b0, "R7 request off when disabled", dma_req, 0);
      chk(dma_mis == 0, "R7 request tracks enable and flag", dma_mis, 0);

      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule